// File: doc/BRIEF.md
# TDM Receive Time-Slot Channel Router

This block sits behind a serial receive pin that carries a framed time-division multiplexed bit stream of the E1 kind. A frame is 32 slots of 8 bits, each slot worth 64 kbit/s, for 2.048 Mbit/s in all. The block runs on the system clock. A one-cycle bit strobe marks each received bit, and a frame sync, sampled with that strobe, marks the first bit of slot 0. From there the block counts bit and slot positions on its own. For every bit it looks up the slot's entry in a receive routing table. If the entry is enabled and the bit is kept by the slot's mask, the bit goes out tagged with the entry's logical channel number.

Any physical slot can be sent to any of 32 logical channels, in any order. When several slots name the same channel they form one wider channel; at most all 32 slots feed a single 2.048 Mbit/s channel. A mask that clears some of a slot's eight bits leaves a narrower channel of N x 8 kbit/s. Slots that are disabled are left for other devices and produce nothing. Each logical channel also has its own packer, which gathers that channel's kept bits into bytes, first bit received in the top bit.

The table is written through a small write port into a shadow copy. The shadow copy moves into the working copy at the next frame sync, so a single frame is always decoded under one configuration.

Top module: `tdm_rx_router`

## Requirements
- R1: While reset is held, and after it is released, `bit_vld` and `byte_vld` are low and every table entry is disabled, so no slot produces output until the table has been written. Every channel packer starts empty.
- R2: Bits are ignored until the first frame sync. The bit whose strobe has `fsync` high is slot 0, bit 0. Each later strobed bit advances the bit index 0..7 and then the slot index 0..31. The position wraps after slot 31, bit 7, and any frame sync restarts it at slot 0, bit 0.
- R3: Take a strobed bit at slot s, bit index p. If entry s is enabled and mask bit (7 - p) of that entry is 1, then on the next clock `bit_vld` is high, `bit_chan` holds the entry's channel and `bit_data` holds the received bit. When no bit is output, `bit_vld`, `bit_chan` and `bit_data` are all 0.
- R4: A bit in a slot whose entry is disabled produces no `bit_vld` and no byte, and it leaves every packer unchanged.
- R5: A bit whose mask bit is 0 produces no output and does not count toward that channel's byte. A slot therefore yields only as many bits as its mask has ones.
- R6: When a channel's eighth kept bit since its last byte arrives, `byte_vld` pulses in the same cycle as that bit's `bit_vld`. `byte_chan` then holds the channel, and `byte_data` holds the eight bits, with the first received in bit 7 and the last in bit 0. Otherwise the byte outputs are 0.
- R7: Kept bits from all slots that name the same channel pack into that channel's bytes in arrival order, across slot and frame boundaries.
- R8: Each channel has its own packer. Bits for one channel never change the partial byte of another channel.
- R9: A write with `cfg_we` high stores {`cfg_valid`, `cfg_chan`, `cfg_mask`} as the shadow entry for `cfg_slot`. The working table takes the whole shadow at the first frame-sync bit seen in a later cycle, and that bit is already decoded with the new table. The bits before it use the old table.
- R10: A cycle with `bit_en` low does not advance the position, produces no output and does not change any packer.
- R11: `fsync` is ignored in a cycle with `bit_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe: a received bit is present this cycle |
| fsync | input | 1 | Frame sync, marks slot 0 bit 0 when `bit_en` is high |
| rx_bit | input | 1 | Received serial bit |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | 5 | Slot whose entry is written |
| cfg_valid | input | 1 | Entry enable |
| cfg_chan | input | 5 | Logical channel of the entry |
| cfg_mask | input | 8 | Bit keep mask, bit 7 gates the first bit of the slot |
| bit_vld | output | 1 | A kept bit is presented |
| bit_chan | output | 5 | Channel of the kept bit |
| bit_data | output | 1 | Value of the kept bit |
| byte_vld | output | 1 | A packed byte is presented |
| byte_chan | output | 5 | Channel of the packed byte |
| byte_data | output | 8 | Packed byte, first received bit in bit 7 |

## Verification
Both result groups have a latency of exactly one clock. The bit and byte outputs that follow a strobed input cycle are registered on the next rising edge. The bench therefore sets each input cycle at a falling edge and compares both groups at the following falling edge, before it sets the next input. A table write takes effect on the frame boundary and not on a fixed cycle count. To cover this, the bench's own model keeps a shadow table and a working table. The model copies the shadow into the working table on the strobed frame-sync bit, before it applies a write issued in that same cycle. Sync-free bits, idle strobes and ignored frame syncs are all checked in the same sample slot, where all outputs must be zero.

// File: rtl/tdm_rx_pkg.sv
// Shared widths and the routing-table entry type of the TDM receive router.
package tdm_rx_pkg;
    localparam int unsigned CHAN_W    = 5;
    localparam int unsigned SLOT_BITS = 8;

    // One routing entry: enable, logical channel and per-bit keep mask.
    typedef struct packed {
        logic                 valid;
        logic [CHAN_W-1:0]    chan;
        logic [SLOT_BITS-1:0] mask;
    } slot_cfg_t;
endpackage

// File: rtl/tdm_frame_counter.sv
// Tracks slot/bit position of each strobed bit of the TDM frame.
// Assumes NUM_SLOTS*SLOT_BITS is a power of two; position restarts on a
// strobed frame sync and nothing is live before the first one.
module tdm_frame_counter #(
    parameter  int unsigned NUM_SLOTS = 32,
    parameter  int unsigned SLOT_BITS = 8,
    localparam int unsigned POS_W     = $clog2(NUM_SLOTS * SLOT_BITS),
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
    localparam int unsigned BIT_W     = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    output logic              live,
    output logic              frame_start,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_SLOTS * SLOT_BITS - 1);

    logic [POS_W-1:0] next_q;
    logic [POS_W-1:0] pos_now;
    logic             sync_q;

    // Position of the bit in this cycle: zero on a frame sync.
    always_comb begin
        pos_now = fsync ? '0 : next_q;
    end

    assign live        = bit_en && (fsync || sync_q);
    assign frame_start = bit_en && fsync;
    assign cur_slot    = pos_now[POS_W-1:BIT_W];
    assign cur_bit     = pos_now[BIT_W-1:0];

    // Advance the position on every live strobed bit and remember sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            sync_q <= 1'b0;
        end else if (live) begin
            next_q <= (pos_now == LAST_POS) ? '0 : pos_now + 1'b1;
            if (fsync) begin
                sync_q <= 1'b1;
            end
        end
    end

    // R10/R11: an idle cycle leaves the position and sync state untouched.
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(next_q) && $stable(sync_q));

    // R2: a strobed frame sync places the next bit at position 1.
    p_sync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> sync_q && (next_q == POS_W'(1)));
endmodule

// File: rtl/tdm_slot_table.sv
// Double-buffered receive routing table. Writes land in the shadow copy;
// the whole shadow moves into the working copy on a frame start. The read
// on a frame-start cycle returns the shadow so that bit already uses it.
module tdm_slot_table
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 32,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_cfg_t         wr_cfg,
    input  logic              swap,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_cfg_t         rd_cfg
);
    slot_cfg_t shadow_q [NUM_SLOTS];
    slot_cfg_t active_q [NUM_SLOTS];

    // Shadow copy: cleared by reset, written one entry at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                shadow_q[i] <= '0;
            end
        end else if (wr_en) begin
            shadow_q[wr_slot] <= wr_cfg;
        end
    end

    // Working copy: cleared by reset, reloaded in full on a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                active_q[i] <= '0;
            end
        end else if (swap) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                active_q[i] <= shadow_q[i];
            end
        end
    end

    // Lookup for the current bit, taking the shadow on the frame-start bit.
    always_comb begin
        rd_cfg = swap ? shadow_q[rd_slot] : active_q[rd_slot];
    end

    // R9: the working entry changes only at a frame start, and then to the
    // shadow value held before that edge.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !swap |=> $stable(active_q[g]));
        p_swap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
            swap |=> active_q[g] == $past(shadow_q[g]));
    end
endmodule

// File: rtl/tdm_byte_packer.sv
// One shift packer per logical channel. Kept bits enter MSB first; the
// eighth bit of a channel emits a registered byte in the cycle after it.
module tdm_byte_packer
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned NUM_CHAN = 2 ** CHAN_W,
    localparam int unsigned CNT_W    = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic                 in_bit,
    output logic                 byte_vld,
    output logic [CHAN_W-1:0]    byte_chan,
    output logic [SLOT_BITS-1:0] byte_data
);
    logic [CNT_W-1:0]     cnt_q [NUM_CHAN];
    logic [SLOT_BITS-2:0] acc_q [NUM_CHAN];
    logic                 full;

    // A byte completes when the addressed channel already holds seven bits.
    assign full = in_vld && (cnt_q[in_chan] == CNT_W'(SLOT_BITS - 1));

    // Per-channel bit count and partial byte, touched only by its own bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CHAN; i++) begin
                cnt_q[i] <= '0;
                acc_q[i] <= '0;
            end
        end else if (in_vld) begin
            cnt_q[in_chan] <= full ? '0 : cnt_q[in_chan] + 1'b1;
            acc_q[in_chan] <= {acc_q[in_chan][SLOT_BITS-3:0], in_bit};
        end
    end

    // Registered byte output, zero when no byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            byte_chan <= '0;
            byte_data <= '0;
        end else begin
            byte_vld  <= full;
            byte_chan <= full ? in_chan : '0;
            byte_data <= full ? {acc_q[in_chan], in_bit} : '0;
        end
    end

    // R6: a byte comes from a kept bit of the same channel, ending in it.
    p_byte_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(in_vld) && (byte_chan == $past(in_chan)));
    p_byte_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> byte_data[0] == $past(in_bit));

    // R8: a channel's count moves only on that channel's own bits.
    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chk
        p_cnt_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_vld && (in_chan == CHAN_W'(g))) |=> $stable(cnt_q[g]));
    end
endmodule

// File: rtl/tdm_rx_router.sv
// Receive time-slot router: positions each strobed bit in the frame, looks
// up its slot entry, gates it by enable and mask, and presents kept bits
// and per-channel packed bytes one clock after the strobe.
// Assumes SLOT_BITS and NUM_SLOTS are powers of two.
module tdm_rx_router
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS = 32,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
    localparam int unsigned BIT_W     = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 fsync,
    input  logic                 rx_bit,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic                 cfg_valid,
    input  logic [CHAN_W-1:0]    cfg_chan,
    input  logic [SLOT_BITS-1:0] cfg_mask,
    output logic                 bit_vld,
    output logic [CHAN_W-1:0]    bit_chan,
    output logic                 bit_data,
    output logic                 byte_vld,
    output logic [CHAN_W-1:0]    byte_chan,
    output logic [SLOT_BITS-1:0] byte_data
);
    logic              live;
    logic              frame_start;
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;
    slot_cfg_t         wr_cfg;
    slot_cfg_t         cur_cfg;
    logic              keep;

    tdm_frame_counter #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .fsync       (fsync),
        .live        (live),
        .frame_start (frame_start),
        .cur_slot    (cur_slot),
        .cur_bit     (cur_bit)
    );

    assign wr_cfg = '{valid: cfg_valid, chan: cfg_chan, mask: cfg_mask};

    tdm_slot_table #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_slot (cfg_slot),
        .wr_cfg  (wr_cfg),
        .swap    (frame_start),
        .rd_slot (cur_slot),
        .rd_cfg  (cur_cfg)
    );

    // Keep the bit when live, its slot is enabled and its mask bit is set;
    // the first bit of a slot (index 0) is gated by the mask MSB.
    always_comb begin
        keep = live && cur_cfg.valid && cur_cfg.mask[~cur_bit];
    end

    // Registered kept-bit output, zero when nothing is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_vld  <= 1'b0;
            bit_chan <= '0;
            bit_data <= 1'b0;
        end else begin
            bit_vld  <= keep;
            bit_chan <= keep ? cur_cfg.chan : '0;
            bit_data <= keep && rx_bit;
        end
    end

    tdm_byte_packer #(
        .NUM_CHAN (2 ** CHAN_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (keep),
        .in_chan   (cur_cfg.chan),
        .in_bit    (rx_bit),
        .byte_vld  (byte_vld),
        .byte_chan (byte_chan),
        .byte_data (byte_data)
    );

    // R6: every byte comes with the kept bit that completed it.
    p_byte_with_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> bit_vld && (bit_chan == byte_chan));

    // R3/R10: a kept bit needs a strobe and carries the received value.
    p_bit_from_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(bit_en) && (bit_data == $past(rx_bit)));
endmodule

// File: tb/tb_tdm_rx_router.sv
`timescale 1ns/100ps
module tb_tdm_rx_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, fsync = 1'b0, rx_bit = 1'b0;
    logic       cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [4:0] cfg_slot = '0, cfg_chan = '0;
    logic [7:0] cfg_mask = '0;
    logic       bit_vld, bit_data, byte_vld;
    logic [4:0] bit_chan, byte_chan;
    logic [7:0] byte_data;

    tdm_rx_router dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .rx_bit(rx_bit),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_valid(cfg_valid),
        .cfg_chan(cfg_chan), .cfg_mask(cfg_mask),
        .bit_vld(bit_vld), .bit_chan(bit_chan), .bit_data(bit_data),
        .byte_vld(byte_vld), .byte_chan(byte_chan), .byte_data(byte_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Bench model of the requirements.
    bit sh_v[32], act_v[32];
    int sh_c[32], act_c[32], sh_m[32], act_m[32];
    int pk_cnt[32], pk_acc[32];
    int m_pos = 0;
    bit m_sync = 1'b0;
    bit w_pend = 1'b0, w_v = 1'b0;
    int w_slot = 0, w_c = 0, w_m = 0;

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic queue_write(int s, bit v, int c, int m);
        w_pend = 1'b1; w_slot = s; w_v = v; w_c = c; w_m = m;
    endtask

    // One input cycle at a falling edge; outputs compared one clock later.
    task automatic step(bit en, bit fs, bit b, string ph);
        int  e_bv = 0, e_bc = 0, e_bd = 0, e_yv = 0, e_yc = 0, e_yd = 0;
        string cat;
        bit_en = en; fsync = fs; rx_bit = b;
        cfg_we = w_pend; cfg_slot = w_slot[4:0]; cfg_valid = w_v;
        cfg_chan = w_c[4:0]; cfg_mask = w_m[7:0];
        if (en) begin
            if (fs) begin
                for (int i = 0; i < 32; i++) begin
                    act_v[i] = sh_v[i]; act_c[i] = sh_c[i]; act_m[i] = sh_m[i];
                end
                m_pos = 0; m_sync = 1'b1;
            end else if (m_sync) begin
                m_pos = (m_pos + 1) % 256;
            end
            if (m_sync) begin
                int s = m_pos / 8;
                int p = m_pos % 8;
                if (!act_v[s]) cat = "R4";
                else if (((act_m[s] >> (7 - p)) & 1) == 0) cat = "R5";
                else begin
                    int c = act_c[s];
                    cat = "R3";
                    e_bv = 1; e_bc = c; e_bd = b;
                    if (pk_cnt[c] == 7) begin
                        e_yv = 1; e_yc = c; e_yd = ((pk_acc[c] << 1) | b) & 255;
                        pk_cnt[c] = 0;
                    end else begin
                        pk_cnt[c]++;
                    end
                    pk_acc[c] = ((pk_acc[c] << 1) | b) & 127;
                end
            end else begin
                cat = "R2";
            end
        end else begin
            cat = fs ? "R11" : "R10";
        end
        if (w_pend) begin
            sh_v[w_slot] = w_v; sh_c[w_slot] = w_c; sh_m[w_slot] = w_m;
            w_pend = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check((ph != "") ? ph : cat, "bit",
              {9'b0, bit_vld, bit_chan, bit_data},
              {9'b0, e_bv[0], e_bc[4:0], e_bd[0]});
        check((ph != "") ? ph : (e_yv != 0 ? "R6" : cat), "byte",
              {2'b0, byte_vld, byte_chan, byte_data},
              {2'b0, e_yv[0], e_yc[4:0], e_yd[7:0]});
        bit_en = 1'b0; fsync = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic run_frame(string ph, int gap_pct);
        for (int i = 0; i < 256; i++) begin
            while (int'($urandom % 100) < gap_pct) step(1'b0, ($urandom % 4) == 0, 1'b0, ph);
            step(1'b1, i == 0, 1'($urandom % 2), ph);
        end
    endtask

    task automatic load_random(string ph);
        for (int s = 0; s < 32; s++) begin
            int m = ($urandom % 3 == 0) ? 255 : int'($urandom % 256);
            queue_write(s, ($urandom % 4) != 0, int'($urandom % 32), m);
            step(1'b0, 1'b0, 1'b0, ph);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 32; i++) begin
            sh_v[i] = 0; act_v[i] = 0; sh_c[i] = 0; act_c[i] = 0;
            sh_m[i] = 0; act_m[i] = 0; pk_cnt[i] = 0; pk_acc[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "reset bit", {9'b0, bit_vld, bit_chan, bit_data}, 16'h0);
        check("R1", "reset byte", {2'b0, byte_vld, byte_chan, byte_data}, 16'h0);
        rst_n = 1'b1;
        // R2: bits before any frame sync are dropped.
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b1, "R2");
        // R1: table starts disabled, a full frame yields nothing.
        run_frame("R1", 0);
        // Random table and random traffic with idle gaps (R3..R6, R10, R11).
        load_random("R9");
        for (int f = 0; f < 6; f++) run_frame("", 10);
        // R9: mid-frame write must not affect the rest of this frame.
        for (int i = 0; i < 256; i++) begin
            if (i == 20) queue_write(10, 1'b1, 9, 8'hC3);
            if (i == 21) queue_write(2, 1'b0, 0, 8'hFF);
            step(1'b1, i == 0, 1'($urandom % 2), "R9");
        end
        run_frame("R9", 5);
        // R7: every slot feeds channel 7 with a full mask.
        for (int s = 0; s < 32; s++) begin
            queue_write(s, 1'b1, 7, 8'hFF);
            step(1'b0, 1'b0, 1'b0, "R7");
        end
        run_frame("R7", 0);
        run_frame("R7", 3);
        // R5: partial masks form a sub channel.
        for (int s = 0; s < 32; s++) begin
            queue_write(s, 1'b1, 3, 8'h5A);
            step(1'b0, 1'b0, 1'b0, "R5");
        end
        run_frame("R5", 0);
        run_frame("R5", 0);
        // R8: two channels interleave slot by slot with disjoint masks.
        for (int s = 0; s < 32; s++) begin
            queue_write(s, 1'b1, (s % 2 == 0) ? 1 : 2, (s % 2 == 0) ? 8'hF0 : 8'h0F);
            step(1'b0, 1'b0, 1'b0, "R8");
        end
        run_frame("R8", 0);
        run_frame("R8", 4);
        // R2: a short frame cut by an early sync restarts the position.
        for (int i = 0; i < 100; i++) step(1'b1, i == 0, 1'($urandom % 2), "R2");
        run_frame("R2", 0);
        // More random mixes.
        load_random("R9");
        for (int f = 0; f < 4; f++) run_frame("", 15);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule